// File: doc/BRIEF.md
# Pipelined Zero-Turnaround Synchronous SRAM

A single-port synchronous SRAM whose word is four 9-bit bytes and whose depth is set by a parameter. Address, operation type and byte enables are captured on a rising clock edge. The data transfer for that operation happens exactly two edges later, whether it is a read or a write. Because the latency is the same for both, reads and writes may be issued on consecutive cycles with no idle bus cycle between them.

An operation is either loaded from the external address or continued from an on-chip four-beat burst counter. The burst visits the four words that share the upper address bits, in linear or interleaved order. A clock-enable style hold input and a sleep input each freeze the whole pipeline. Three chip selects of mixed polarity gate the start of new operations. The bidirectional data bus is modelled as a separate input, a separate output and an output-drive flag. An asynchronous output enable can force the drive flag off.

Top module: `zbt_sram`

## Requirements
- R1: A read loaded on rising edge E puts the addressed word on `dout` and raises `dout_oe` after edge E+2, provided `oe_n` is low and every edge from E to E+2 is active. Reads are back-to-back with no idle cycle.
- R2: A write loaded on edge E takes `din` at edge E+2. `dout_oe` stays low after that edge.
- R3: `byte_we_n[i]` low selects `din[9*i+8:9*i]` for writing. A byte whose bit is high keeps its old value. Byte enables are ignored for reads.
- R4: A write followed on the next cycle by a read of the same address returns the newly written word.
- R5: While `hold` is high at an edge, that edge changes no state: inputs including `din` are ignored and `dout`/`dout_oe` keep their values.
- R6: A load happens only when `advance`=0, `sel_a_n`=0, `sel_b_n`=0 and `sel_c`=1. Any other chip-select combination with `advance`=0 is a deselect: it ends any burst, operations already issued still complete, and `dout_oe` is low two edges later.
- R7: `advance`=1 during a burst issues the next beat with the same operation type. The external address and `wr_n` are ignored. The upper address bits equal the loaded address, and beat k (k counted mod 4) uses low bits base+k (mod 4) when `burst_ilv`=0, or base XOR k when `burst_ilv`=1. Write beats use the byte enables of their own cycle.
- R8: `advance`=1 with no burst in progress (after a deselect) issues nothing: no write and no drive.
- R9: `oe_n` high forces `dout_oe` low at once, without a clock edge, and does not disturb the pipeline.
- R10: While `sleep` is high no state changes, and the array contents are retained.
- R11: After reset `dout_oe` is low, `dout` is zero and no burst is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the pipeline |
| hold | input | 1 | High: freeze the entire block at this edge |
| sleep | input | 1 | High: gate internal clocking, contents retained |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b_n | input | 1 | Chip select, active low |
| sel_c | input | 1 | Chip select, active high |
| wr_n | input | 1 | Operation of a load: 0 write, 1 read |
| advance | input | 1 | 1 continue burst, 0 load new address / deselect |
| addr | input | ADDR_W | Word address for a load |
| byte_we_n | input | NBYTES | Per-byte write enables, active low |
| burst_ilv | input | 1 | Burst order: 0 linear, 1 interleaved |
| oe_n | input | 1 | Asynchronous output enable, active low |
| din | input | NBYTES*BYTE_W | Write data, sampled at the data phase |
| dout | output | NBYTES*BYTE_W | Registered read data |
| dout_oe | output | 1 | High when the block drives the data bus |

## Verification
The hardest case to reach is a freeze that arrives while operations sit between issue and data phase. This matters most for a write whose data phase is postponed, because that write must take `din` from the first active edge after the freeze, not from the frozen edge. The stimulus places `hold` and `sleep` cycles one and two cycles after loads and changes `din` on every frozen cycle. A reference model that advances only on active edges then exposes any data captured at the wrong edge. Advance cycles after a deselect follow a burst write, and the same words are read back afterwards. This shows that a stale burst never resumes.

// File: rtl/zbt_pkg.sv
package zbt_pkg;

    // Width of the on-chip burst beat counter (four-beat bursts)
    localparam int BEAT_W = 2;

    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } burst_ord_e;

    // Low address bits of a burst beat (R7)
    function automatic logic [BEAT_W-1:0] beat_lsb(
        input burst_ord_e        ord,
        input logic [BEAT_W-1:0] base,
        input logic [BEAT_W-1:0] beat
    );
        logic [BEAT_W-1:0] res;
        if (ord == ORD_INTERLEAVE) res = base ^ beat;
        else                       res = base + beat;
        return res;
    endfunction

endpackage

// File: rtl/zbt_cmd_pipe.sv
module zbt_cmd_pipe
    import zbt_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int NBYTES = 4,
    parameter int LAT    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              advance,
    input  logic              sel_ok,
    input  logic              wr_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [NBYTES-1:0] byte_we_n,
    input  logic              burst_ilv,
    output logic              ph_valid,
    output logic              ph_wr,
    output logic [ADDR_W-1:0] ph_addr,
    output logic [NBYTES-1:0] ph_be
);

    typedef struct packed {
        logic              valid;
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [NBYTES-1:0] be;
    } op_t;

    typedef struct packed {
        logic              active;
        logic              wr;
        burst_ord_e        ord;
        logic [ADDR_W-1:0] base;
        logic [BEAT_W-1:0] beat;
        op_t [LAT-1:0]     pipe;
    } st_t;

    st_t               st_d, st_q;
    op_t               issue;
    logic [BEAT_W-1:0] next_beat;

    always_comb begin
        st_d      = st_q;
        issue     = '0;
        next_beat = st_q.beat + 1'b1;

        // R6: load needs all three selects true; R7: advance continues burst
        if (!advance) begin
            if (sel_ok) begin
                issue.valid = 1'b1;
                issue.wr    = !wr_n;
                issue.addr  = addr;
                issue.be    = wr_n ? '0 : ~byte_we_n;
            end
        end else if (st_q.active) begin
            issue.valid = 1'b1;
            issue.wr    = st_q.wr;
            issue.addr  = {st_q.base[ADDR_W-1:BEAT_W],
                           beat_lsb(st_q.ord, st_q.base[BEAT_W-1:0], next_beat)};
            issue.be    = st_q.wr ? ~byte_we_n : '0;
        end

        // R5/R10: nothing moves on a frozen edge
        if (tick) begin
            if (!advance) begin
                st_d.active = sel_ok;
                if (sel_ok) begin
                    st_d.wr   = !wr_n;
                    st_d.ord  = burst_ord_e'(burst_ilv);
                    st_d.base = addr;
                    st_d.beat = '0;
                end
            end else if (st_q.active) begin
                st_d.beat = next_beat;
            end
            for (int i = LAT - 1; i > 0; i--) begin
                st_d.pipe[i] = st_q.pipe[i-1];
            end
            st_d.pipe[0] = issue;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ph_valid = st_q.pipe[LAT-1].valid;
    assign ph_wr    = st_q.pipe[LAT-1].wr;
    assign ph_addr  = st_q.pipe[LAT-1].addr;
    assign ph_be    = st_q.pipe[LAT-1].be;

endmodule

// File: rtl/zbt_array.sv
module zbt_array #(
    parameter int ADDR_W = 8,
    parameter int BYTE_W = 9,
    parameter int NBYTES = 4
) (
    input  logic                     clk,
    input  logic                     we,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [NBYTES-1:0]        wr_be,
    input  logic [NBYTES*BYTE_W-1:0] wr_word,
    input  logic [ADDR_W-1:0]        rd_addr,
    output logic [NBYTES*BYTE_W-1:0] rd_word
);

    localparam int DEPTH = 1 << ADDR_W;

    // One bank per byte lane so each lane has its own write strobe (R3)
    for (genvar b = 0; b < NBYTES; b++) begin : g_lane
        logic [BYTE_W-1:0] bank [DEPTH];

        always_ff @(posedge clk) begin
            if (we && wr_be[b]) bank[wr_addr] <= wr_word[b*BYTE_W +: BYTE_W];
        end

        assign rd_word[b*BYTE_W +: BYTE_W] = bank[rd_addr];
    end

endmodule

// File: rtl/zbt_out_reg.sv
module zbt_out_reg #(
    parameter int DATA_W = 36
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              ph_rd,
    input  logic [DATA_W-1:0] rd_word,
    input  logic              oe_n,
    output logic [DATA_W-1:0] dout,
    output logic              dout_oe
);

    typedef struct packed {
        logic              drive;
        logic [DATA_W-1:0] word;
    } out_t;

    out_t out_d, out_q;

    always_comb begin
        out_d = out_q;
        if (tick) begin
            out_d.drive = ph_rd;
            if (ph_rd) out_d.word = rd_word;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign dout    = out_q.word;
    // R9: asynchronous gate of the registered drive flag
    assign dout_oe = out_q.drive & ~oe_n;

endmodule

// File: rtl/zbt_sram.sv
module zbt_sram #(
    parameter int ADDR_W = 8,
    parameter int BYTE_W = 9,
    parameter int NBYTES = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     hold,
    input  logic                     sleep,
    input  logic                     sel_a_n,
    input  logic                     sel_b_n,
    input  logic                     sel_c,
    input  logic                     wr_n,
    input  logic                     advance,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [NBYTES-1:0]        byte_we_n,
    input  logic                     burst_ilv,
    input  logic                     oe_n,
    input  logic [NBYTES*BYTE_W-1:0] din,
    output logic [NBYTES*BYTE_W-1:0] dout,
    output logic                     dout_oe
);

    localparam int DATA_W = NBYTES * BYTE_W;
    localparam int LAT    = 2;

    logic              tick;
    logic              sel_ok;
    logic              ph_valid;
    logic              ph_wr;
    logic [ADDR_W-1:0] ph_addr;
    logic [NBYTES-1:0] ph_be;
    logic [DATA_W-1:0] rd_word;

    assign tick   = !hold && !sleep;
    assign sel_ok = !sel_a_n && !sel_b_n && sel_c;

    zbt_cmd_pipe #(
        .ADDR_W (ADDR_W),
        .NBYTES (NBYTES),
        .LAT    (LAT)
    ) u_cmd (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .advance   (advance),
        .sel_ok    (sel_ok),
        .wr_n      (wr_n),
        .addr      (addr),
        .byte_we_n (byte_we_n),
        .burst_ilv (burst_ilv),
        .ph_valid  (ph_valid),
        .ph_wr     (ph_wr),
        .ph_addr   (ph_addr),
        .ph_be     (ph_be)
    );

    // R4: write commits at its data phase, before any later read phase
    zbt_array #(
        .ADDR_W (ADDR_W),
        .BYTE_W (BYTE_W),
        .NBYTES (NBYTES)
    ) u_array (
        .clk     (clk),
        .we      (tick && ph_valid && ph_wr),
        .wr_addr (ph_addr),
        .wr_be   (ph_be),
        .wr_word (din),
        .rd_addr (ph_addr),
        .rd_word (rd_word)
    );

    zbt_out_reg #(
        .DATA_W (DATA_W)
    ) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .ph_rd   (ph_valid && !ph_wr),
        .rd_word (rd_word),
        .oe_n    (oe_n),
        .dout    (dout),
        .dout_oe (dout_oe)
    );

endmodule

// File: rtl/zbt_sram_chk.sv
module zbt_sram_chk #(
    parameter int DATA_W = 36
) (
    input logic              clk,
    input logic              rst_n,
    input logic              hold,
    input logic              sleep,
    input logic              sel_a_n,
    input logic              sel_b_n,
    input logic              sel_c,
    input logic              wr_n,
    input logic              advance,
    input logic              oe_n,
    input logic [DATA_W-1:0] dout,
    input logic              dout_oe
);

    logic tick, sel_ok, rd_load, wr_load, desel;

    assign tick    = !hold && !sleep;
    assign sel_ok  = !sel_a_n && !sel_b_n && sel_c;
    assign rd_load = tick && !advance && sel_ok && wr_n;
    assign wr_load = tick && !advance && sel_ok && !wr_n;
    assign desel   = tick && !advance && !sel_ok;

    a_r1_read_drives: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n, 3) && $past(rd_load, 3) && $past(tick, 2) && $past(tick) && !oe_n)
        |-> dout_oe);

    a_r2_write_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n, 3) && $past(wr_load, 3) && $past(tick, 2) && $past(tick))
        |-> !dout_oe);

    a_r6_deselect_floats: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n, 3) && $past(desel, 3) && $past(tick, 2) && $past(tick))
        |-> !dout_oe);

    a_r5_hold_data: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(hold)) |-> $stable(dout));

    a_r5_hold_drive: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(hold) && $stable(oe_n)) |-> $stable(dout_oe));

    a_r10_sleep_data: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(sleep)) |-> $stable(dout));

endmodule

bind zbt_sram zbt_sram_chk #(.DATA_W(DATA_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .hold    (hold),
    .sleep   (sleep),
    .sel_a_n (sel_a_n),
    .sel_b_n (sel_b_n),
    .sel_c   (sel_c),
    .wr_n    (wr_n),
    .advance (advance),
    .oe_n    (oe_n),
    .dout    (dout),
    .dout_oe (dout_oe)
);

// File: tb/zbt_sram_bench.sv
module zbt_sram_bench;

    localparam int AW    = 8;
    localparam int BW    = 9;
    localparam int NB    = 4;
    localparam int DW    = NB * BW;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          hold, sleep, sel_a_n, sel_b_n, sel_c, wr_n, advance, burst_ilv, oe_n;
    logic [AW-1:0] addr;
    logic [NB-1:0] byte_we_n;
    logic [DW-1:0] din, dout;
    logic          dout_oe;

    always #4 clk = ~clk;   // 125 MHz

    zbt_sram #(.ADDR_W(AW), .BYTE_W(BW), .NBYTES(NB)) u_zbt_sram (
        .clk(clk), .rst_n(rst_n), .hold(hold), .sleep(sleep),
        .sel_a_n(sel_a_n), .sel_b_n(sel_b_n), .sel_c(sel_c),
        .wr_n(wr_n), .advance(advance), .addr(addr), .byte_we_n(byte_we_n),
        .burst_ilv(burst_ilv), .oe_n(oe_n), .din(din),
        .dout(dout), .dout_oe(dout_oe)
    );

    typedef struct {
        logic          drive;
        logic [DW-1:0] data;
        logic          oe;
        int            req;
    } exp_t;

    typedef struct packed {
        logic          v;
        logic          wr;
        logic [AW-1:0] a;
        logic [NB-1:0] be;
    } mop_t;

    exp_t          sb_q[$];
    int            n_vec = 0;
    int            n_bad = 0;
    bit            done  = 1'b0;

    // reference model, stepped only on active edges
    logic [DW-1:0] mm [DEPTH];
    mop_t          p1, p2;
    logic          b_on, b_wr, b_ord;
    logic [AW-1:0] b_base;
    logic [1:0]    b_k;
    logic          e_drive;
    logic [DW-1:0] e_data;
    logic [31:0]   lfsr;

    task automatic chk(input bit ok, input int r, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL R%0d: actual %h expected %h", r, act, exp);
        end
    endtask

    // driver: sets inputs for the next edge and pushes its expected outcome
    task automatic drive(input logic a_adv, input logic [2:0] sel, input logic a_wr_n,
                         input logic [AW-1:0] a_addr, input logic [NB-1:0] a_be_n,
                         input logic a_ord, input logic a_hold, input logic a_sleep,
                         input logic a_oe_n, input int req);
        mop_t nop;
        @(negedge clk);
        #1;
        lfsr      = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        advance   = a_adv;
        {sel_a_n, sel_b_n, sel_c} = sel;
        wr_n      = a_wr_n;
        addr      = a_addr;
        byte_we_n = a_be_n;
        burst_ilv = a_ord;
        hold      = a_hold;
        sleep     = a_sleep;
        oe_n      = a_oe_n;
        din       = {lfsr[7:4], lfsr};
        if (!a_hold && !a_sleep) begin
            if (p2.v && p2.wr)
                for (int b = 0; b < NB; b++)
                    if (p2.be[b]) mm[p2.a][b*BW +: BW] = din[b*BW +: BW];
            if (p2.v && !p2.wr) begin
                e_drive = 1'b1;
                e_data  = mm[p2.a];
            end else begin
                e_drive = 1'b0;
            end
            nop = '0;
            if (!a_adv) begin
                if (sel == 3'b001) begin
                    b_on = 1'b1; b_wr = !a_wr_n; b_ord = a_ord; b_base = a_addr; b_k = 2'd0;
                    nop.v = 1'b1; nop.wr = !a_wr_n; nop.a = a_addr; nop.be = ~a_be_n;
                end else begin
                    b_on = 1'b0;
                end
            end else if (b_on) begin
                b_k    = b_k + 2'd1;
                nop.v  = 1'b1;
                nop.wr = b_wr;
                nop.a  = {b_base[AW-1:2], b_ord ? (b_base[1:0] ^ b_k) : (b_base[1:0] + b_k)};
                nop.be = ~a_be_n;
            end
            p2 = p1;
            p1 = nop;
        end
        sb_q.push_back('{e_drive, e_data, a_oe_n, req});
    endtask

    task automatic ld(input logic w, input logic [AW-1:0] a, input logic [NB-1:0] ben,
                      input logic ord, input int r);
        drive(1'b0, 3'b001, !w, a, ben, ord, 1'b0, 1'b0, 1'b0, r);
    endtask

    task automatic adv(input logic [NB-1:0] ben, input int r);
        drive(1'b1, {lfsr[3], lfsr[5], lfsr[6]}, lfsr[9], lfsr[AW+1:2], ben, lfsr[11],
              1'b0, 1'b0, 1'b0, r);
    endtask

    task automatic desel(input logic [2:0] s, input int r);
        drive(1'b0, s, lfsr[2], lfsr[AW+3:4], lfsr[3:0], 1'b0, 1'b0, 1'b0, 1'b0, r);
    endtask

    task automatic frz(input logic h, input logic s, input int r);
        drive(lfsr[0], 3'b001, lfsr[1], lfsr[AW+1:2], lfsr[7:4], lfsr[8], h, s, 1'b0, r);
    endtask

    // monitor: pops one expected item per edge, half a cycle after it
    always @(negedge clk) begin : mon
        exp_t e;
        if (sb_q.size() != 0) begin
            e = sb_q.pop_front();
            n_vec++;
            if (dout_oe !== (e.drive && !e.oe)) begin
                n_bad++;
                $display("FAIL R%0d: dout_oe actual %b expected %b", e.req, dout_oe, e.drive && !e.oe);
            end else if (e.drive && dout !== e.data) begin
                n_bad++;
                $display("FAIL R%0d: dout actual %h expected %h", e.req, dout, e.data);
            end
        end
    end

    initial begin : watchdog
        #(8 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL R0: watchdog actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin : main
        lfsr = 32'h1ACE_5EED;
        p1 = '0; p2 = '0; b_on = 1'b0; b_wr = 1'b0; b_ord = 1'b0; b_base = '0; b_k = '0;
        e_drive = 1'b0; e_data = '0;
        rst_n = 1'b0; hold = 1'b0; sleep = 1'b0; advance = 1'b0;
        sel_a_n = 1'b0; sel_b_n = 1'b0; sel_c = 1'b0; wr_n = 1'b1; addr = '0;
        byte_we_n = '1; burst_ilv = 1'b0; oe_n = 1'b0; din = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R11: reset state
        chk(dout_oe === 1'b0, 11, {35'd0, dout_oe}, '0);
        chk(dout === '0, 11, dout, '0);

        // R2, R7: fill the array with linear four-beat burst writes
        for (int base = 0; base < DEPTH; base += 4) begin
            ld(1'b1, AW'(base), 4'b0000, 1'b0, 2);
            repeat (3) adv(4'b0000, 7);
        end
        desel(3'b000, 6);

        // R1: back-to-back reads, byte enables ignored
        for (int i = 0; i < 16; i++) ld(1'b0, AW'(i * 13), lfsr[3:0], 1'b0, 1);

        // R4: write then read of the same address on the next cycle
        for (int i = 0; i < 8; i++) begin
            ld(1'b1, AW'(40 + i), 4'b0000, 1'b0, 4);
            ld(1'b0, AW'(40 + i), 4'b1111, 1'b0, 4);
        end
        ld(1'b0, 8'd90, 4'b0000, 1'b0, 4);
        ld(1'b1, 8'd90, 4'b0000, 1'b0, 4);
        ld(1'b0, 8'd90, 4'b0000, 1'b0, 4);

        // R3: partial byte writes, and a write with no bytes selected
        ld(1'b1, 8'd100, 4'b1010, 1'b0, 3);
        ld(1'b1, 8'd101, 4'b0111, 1'b0, 3);
        ld(1'b1, 8'd102, 4'b1111, 1'b0, 3);
        ld(1'b0, 8'd100, 4'b0000, 1'b0, 3);
        ld(1'b0, 8'd101, 4'b0000, 1'b0, 3);
        ld(1'b0, 8'd102, 4'b0000, 1'b0, 3);

        // R7: interleaved and linear bursts, wrapping past four beats
        ld(1'b0, 8'h22, 4'b0000, 1'b1, 7);
        repeat (7) adv(4'b0000, 7);
        ld(1'b0, 8'h31, 4'b0000, 1'b0, 7);
        repeat (5) adv(4'b0000, 7);
        ld(1'b1, 8'h57, 4'b0000, 1'b1, 7);
        adv(4'b0101, 7);
        adv(4'b0011, 7);
        adv(4'b0000, 7);
        ld(1'b0, 8'h54, 4'b0000, 1'b0, 7);
        repeat (3) adv(4'b0000, 7);

        // R6: each select false in turn, pending reads still complete
        ld(1'b0, 8'd10, 4'b0000, 1'b0, 6);
        desel(3'b101, 6);
        ld(1'b0, 8'd11, 4'b0000, 1'b0, 6);
        desel(3'b011, 6);
        ld(1'b1, 8'd12, 4'b0000, 1'b0, 6);
        desel(3'b000, 6);
        desel(3'b111, 6);
        ld(1'b0, 8'd12, 4'b0000, 1'b0, 6);

        // R8: advance after deselect must not resume the burst write
        ld(1'b1, 8'h60, 4'b0000, 1'b0, 8);
        repeat (3) adv(4'b0000, 8);
        desel(3'b000, 8);
        repeat (4) adv(4'b0000, 8);
        for (int i = 0; i < 4; i++) ld(1'b0, AW'(8'h60 + i), 4'b0000, 1'b0, 8);

        // R5: hold inserted one and two cycles after loads
        ld(1'b0, 8'd20, 4'b0000, 1'b0, 5);
        repeat (3) frz(1'b1, 1'b0, 5);
        ld(1'b1, 8'd21, 4'b0000, 1'b0, 5);
        frz(1'b1, 1'b0, 5);
        ld(1'b0, 8'd22, 4'b0000, 1'b0, 5);
        repeat (2) frz(1'b1, 1'b0, 5);
        ld(1'b0, 8'd21, 4'b0000, 1'b0, 5);
        desel(3'b000, 5);

        // R10: sleep during a pending write and a pending read
        ld(1'b1, 8'd30, 4'b0000, 1'b0, 10);
        repeat (4) frz(1'b0, 1'b1, 10);
        ld(1'b0, 8'd30, 4'b0000, 1'b0, 10);
        repeat (2) frz(1'b0, 1'b1, 10);
        ld(1'b0, 8'd31, 4'b0000, 1'b0, 10);
        desel(3'b000, 10);

        // R9: output enable high during read data phases
        ld(1'b0, 8'd5, 4'b0000, 1'b0, 9);
        ld(1'b0, 8'd6, 4'b0000, 1'b0, 9);
        drive(1'b0, 3'b000, 1'b1, 8'd0, 4'hF, 1'b0, 1'b0, 1'b0, 1'b1, 9);
        drive(1'b0, 3'b000, 1'b1, 8'd0, 4'hF, 1'b0, 1'b0, 1'b0, 1'b0, 9);
        // R9: asynchronous response while the pipeline is held with drive on
        ld(1'b0, 8'd7, 4'b0000, 1'b0, 9);
        desel(3'b000, 9);
        desel(3'b000, 9);
        frz(1'b1, 1'b0, 9);
        @(posedge clk);
        #1;
        oe_n = 1'b1;
        #1;
        chk(dout_oe === 1'b0, 9, {35'd0, dout_oe}, '0);
        oe_n = 1'b0;
        #1;
        chk(dout_oe === 1'b1, 9, {35'd0, dout_oe}, 36'd1);
        ld(1'b0, 8'd7, 4'b0000, 1'b0, 9);

        repeat (3) desel(3'b000, 6);
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule